// File: doc/BRIEF.md
# Master TDM Serial Audio Port

This block is a master-side serial audio port for PCM samples. It divides the system clock down to a bit clock and a frame sync and drives both toward an external converter. Every frame has two 32-bit time slots: slot 0 carries the left sample and slot 1 carries the right sample. Framing follows the usual I2S convention, with the bit clock and the frame sync both non-inverted. Transmit and receive run from the same clock pair, so one frame always carries one outgoing sample pair and collects one incoming sample pair.

A two-bit, active-low slot mask picks which slots carry data. Mono uses only slot 0 and stereo uses both slots; the framing is otherwise the same. Samples enter and leave through parallel 24-bit left and right words with valid/ready handshakes. The word length is 16 or 24 bits, packed MSB first at the head of the slot. The divider, word length and mask are taken only at frame boundaries, so a configuration change never breaks a frame.

Top module: `tdm_port`

## Requirements
- R1: The bit clock high phase and low phase each last max(cfgDiv,1) system clock cycles, so one bit period is 2·max(cfgDiv,1) cycles.
- R2: A frame is 64 bit periods. The frame sync is low for periods 0–31 and high for periods 32–63, and it changes only together with a falling bit clock edge.
- R3: The transmit line changes only with a falling bit clock edge. Bit p of the frame (p = 0..63, slot = p/32, position j = p mod 32) is driven in bit period (p+1) mod 64, so each slot's MSB follows one period after a frame sync edge. Bits go out MSB first.
- R4: With cfgWord24=1 a slot carries the full 24-bit word. With cfgWord24=0 it carries bits 23..8 of the word. All positions j at or beyond the word length are sent as 0.
- R5: cfgMask bit 0 controls slot 0 (left) and bit 1 controls slot 1 (right). A 0 enables the slot, and the transmit line is low for the whole of a disabled slot.
- R6: The receive line is sampled on rising bit clock edges with the R3 mapping. Received words are MSB-aligned in 24 bits, with bits 7..0 at zero for 16-bit words. A disabled slot's bits are discarded and it is reported as 0.
- R7: Exactly one received pair is offered per frame, with rxValid rising together with the falling frame sync edge. rxValid stays high until rxReady is seen.
- R8: The transmit side holds one sample pair. txReady is low while that pair waits, and the pair is sent in the next frame. If no pair is waiting at a frame start, that frame sends zeros.
- R9: During reset the bit clock, frame sync and transmit line are low, txReady is high and rxValid is low.
- R10: cfgDiv, cfgWord24 and cfgMask are taken at the falling bit clock edge that starts period 0. A change made in mid-frame does not alter the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgDiv | input | 8 | Half bit-clock period in system clocks (0 acts as 1) |
| cfgWord24 | input | 1 | 1: 24-bit words, 0: 16-bit words |
| cfgMask | input | 2 | Active-low slot enables, bit 0 = slot 0 |
| txValid | input | 1 | Transmit pair offered |
| txReady | output | 1 | Transmit holding entry free |
| txLeft | input | 24 | Slot 0 transmit word |
| txRight | input | 24 | Slot 1 transmit word |
| rxValid | output | 1 | Received pair available |
| rxReady | input | 1 | Received pair taken |
| rxLeft | output | 24 | Slot 0 received word |
| rxRight | output | 24 | Slot 1 received word |
| bclk | output | 1 | Bit clock |
| fs | output | 1 | Frame sync |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
The bench sweeps every combination of word length, slot mask and receive source. It feeds the receive line either from the transmit line, which gives a loopback of distinct sample patterns, or from a constant high level. The constant-high source shows that masked slots and trailing bits are dropped and not just mirrored from the transmit side. An independent decoder rebuilds each transmitted frame and the frame sync schedule from the pins alone. Separate runs cover an idle start where no data is offered, divider values of 0, 3 and 5, and a divider change made in mid-frame that must not take effect until the next boundary.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int SLOTS     = 2;
  localparam int SLOT_BITS = 32;
  localparam int WORD_W    = 24;
  localparam int SHORT_W   = 16;
  localparam int SLOT_W    = $clog2(SLOT_BITS);
  localparam int SEL_W     = $clog2(SLOTS);
  localparam int POS_W     = SLOT_W + SEL_W;

  // strobes from the timing control to the datapath
  typedef struct packed {
    logic             fall;        // bit clock falls this cycle
    logic             rise;        // bit clock rises this cycle
    logic             frameStart;  // fall that opens period 0
    logic [POS_W-1:0] txPos;       // frame bit driven after this fall
    logic [POS_W-1:0] rxPos;       // frame bit sampled at this rise
    logic             wordLong;    // active word length is 24
    logic [SLOTS-1:0] mask;        // active-low slot enables
  } tdmStrobe_t;
endpackage

// File: rtl/tdm_ctrl.sv
module tdm_ctrl
  import tdm_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DEF_DIV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             cfgWord24,
  input  logic [SLOTS-1:0] cfgMask,
  output logic             bclk,
  output logic             fs,
  output tdmStrobe_t       strb
);
  logic [DIV_W-1:0] divCnt, actDiv, effDiv;
  logic [POS_W-1:0] periodQ, periodNext;
  logic             bclkQ, fsQ, actLong, tick;
  logic [SLOTS-1:0] actMask;

  assign effDiv     = (actDiv == '0) ? DIV_W'(1) : actDiv;
  assign tick       = (divCnt == effDiv - DIV_W'(1));
  assign periodNext = periodQ + POS_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      actDiv  <= DIV_W'(DEF_DIV);
      bclkQ   <= 1'b0;
      fsQ     <= 1'b0;
      periodQ <= '1;          // next fall opens period 0
      actLong <= 1'b1;
      actMask <= '0;
    end else if (tick) begin
      divCnt <= '0;
      bclkQ  <= ~bclkQ;
      if (bclkQ) begin
        periodQ <= periodNext;
        fsQ     <= (periodNext >= POS_W'(SLOT_BITS));
        if (periodNext == '0) begin
          actDiv  <= cfgDiv;
          actLong <= cfgWord24;
          actMask <= cfgMask;
        end
      end
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_comb begin
    strb.fall       = tick & bclkQ;
    strb.rise       = tick & ~bclkQ;
    strb.frameStart = tick & bclkQ & (periodNext == '0);
    strb.txPos      = periodQ;              // period k carries bit k-1
    strb.rxPos      = periodQ - POS_W'(1);
    strb.wordLong   = actLong;
    strb.mask       = actMask;
  end

  assign bclk = bclkQ;
  assign fs   = fsQ;
endmodule

// File: rtl/tdm_dp.sv
module tdm_dp
  import tdm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tdmStrobe_t        strb,
  input  logic              txValid,
  output logic              txReady,
  input  logic [WORD_W-1:0] txLeft,
  input  logic [WORD_W-1:0] txRight,
  output logic              rxValid,
  input  logic              rxReady,
  output logic [WORD_W-1:0] rxLeft,
  output logic [WORD_W-1:0] rxRight,
  output logic              txd,
  input  logic              rxd
);
  logic [WORD_W-1:0] hold   [SLOTS];
  logic [WORD_W-1:0] txWord [SLOTS];
  logic [WORD_W-1:0] rxSh   [SLOTS];
  logic [WORD_W-1:0] rxOut  [SLOTS];
  logic [WORD_W-1:0] txShifted, rxBitMask;
  logic              holdFull, txdQ, rxvQ, seenFrame, txBit, rxTake;
  logic [SLOT_W-1:0] wordLen, txJ, rxJ;
  logic [SEL_W-1:0]  txS, rxS;

  assign wordLen   = strb.wordLong ? SLOT_W'(WORD_W) : SLOT_W'(SHORT_W);
  assign txS       = strb.txPos[POS_W-1 -: SEL_W];
  assign txJ       = strb.txPos[SLOT_W-1:0];
  assign rxS       = strb.rxPos[POS_W-1 -: SEL_W];
  assign rxJ       = strb.rxPos[SLOT_W-1:0];
  assign txShifted = txWord[txS] << txJ;
  assign txBit     = ~strb.mask[txS] & (txJ < wordLen) & txShifted[WORD_W-1];
  assign rxTake    = ~strb.mask[rxS] & (rxJ < wordLen);
  assign rxBitMask = WORD_W'(1) << (SLOT_W'(WORD_W - 1) - rxJ);
  assign txReady   = ~holdFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdFull  <= 1'b0;
      txdQ      <= 1'b0;
      rxvQ      <= 1'b0;
      seenFrame <= 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
        hold[i]   <= '0;
        txWord[i] <= '0;
        rxSh[i]   <= '0;
        rxOut[i]  <= '0;
      end
    end else begin
      // transmit holding entry
      if (strb.frameStart) holdFull <= 1'b0;
      if (txValid && !holdFull) begin
        hold[0]  <= txLeft;
        hold[1]  <= txRight;
        holdFull <= 1'b1;
      end
      if (strb.frameStart) begin
        seenFrame <= 1'b1;
        for (int i = 0; i < SLOTS; i++) begin
          txWord[i] <= holdFull ? hold[i] : '0;
          rxOut[i]  <= rxSh[i];
          rxSh[i]   <= '0;
        end
      end
      if (strb.fall) txdQ <= txBit;
      if (strb.rise && rxTake && rxd) rxSh[rxS] <= rxSh[rxS] | rxBitMask;
      // receive delivery
      if (strb.frameStart && seenFrame) rxvQ <= 1'b1;
      else if (rxReady)                 rxvQ <= 1'b0;
    end
  end

  assign txd     = txdQ;
  assign rxValid = rxvQ;
  assign rxLeft  = rxOut[0];
  assign rxRight = rxOut[1];
endmodule

// File: rtl/tdm_port.sv
module tdm_port
  import tdm_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int DEF_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic              cfgWord24,
  input  logic [SLOTS-1:0]  cfgMask,
  input  logic              txValid,
  output logic              txReady,
  input  logic [WORD_W-1:0] txLeft,
  input  logic [WORD_W-1:0] txRight,
  output logic              rxValid,
  input  logic              rxReady,
  output logic [WORD_W-1:0] rxLeft,
  output logic [WORD_W-1:0] rxRight,
  output logic              bclk,
  output logic              fs,
  output logic              txd,
  input  logic              rxd
);
  tdmStrobe_t strb;

  tdm_ctrl #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgDiv(cfgDiv), .cfgWord24(cfgWord24),
    .cfgMask(cfgMask), .bclk(bclk), .fs(fs), .strb(strb)
  );

  tdm_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txValid(txValid), .txReady(txReady), .txLeft(txLeft), .txRight(txRight),
    .rxValid(rxValid), .rxReady(rxReady), .rxLeft(rxLeft), .rxRight(rxRight),
    .txd(txd), .rxd(rxd)
  );
endmodule

// File: rtl/tdm_port_chk.sv
module tdm_port_chk (
  input logic clk,
  input logic rstN,
  input logic bclk,
  input logic fs,
  input logic txd,
  input logic txValid,
  input logic txReady,
  input logic rxValid,
  input logic rxReady
);
  AST_FS_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fs) |-> $fell(bclk)); // R2
  AST_TXD_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txd) |-> $fell(bclk)); // R3
  AST_RX_AT_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> $fell(fs)); // R7
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !rxReady |=> rxValid); // R7
  AST_TX_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady |=> !txReady); // R8
endmodule

bind tdm_port tdm_port_chk u_chk (
  .clk(clk), .rstN(rstN), .bclk(bclk), .fs(fs), .txd(txd),
  .txValid(txValid), .txReady(txReady), .rxValid(rxValid), .rxReady(rxReady)
);

// File: tb/tdm_port_bench.sv
module tdm_port_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  cfgDiv;
  logic        cfgWord24;
  logic [1:0]  cfgMask;
  logic        txValid, txReady, rxValid, rxReady;
  logic [23:0] txLeft, txRight, rxLeft, rxRight;
  logic        bclk, fs, txd, rxd, loopSel;

  always #10 clk = ~clk;  // 50 MHz
  assign rxd = loopSel ? txd : 1'b1;

  tdm_port u_tdm_port (
    .clk(clk), .rstN(rstN), .cfgDiv(cfgDiv), .cfgWord24(cfgWord24), .cfgMask(cfgMask),
    .txValid(txValid), .txReady(txReady), .txLeft(txLeft), .txRight(txRight),
    .rxValid(rxValid), .rxReady(rxReady), .rxLeft(rxLeft), .rxRight(rxRight),
    .bclk(bclk), .fs(fs), .txd(txd), .rxd(rxd)
  );

  int nChecks = 0, nFail = 0, cyc = 0;
  int pos = -1, gap = 0, lastGap = 0, frames = 0, rxPerFrame = 0, expHalf = 2;
  bit prevBclk = 0, prevFs = 0, compare = 0, fullFrame = 0, gapBad = 0;
  logic [63:0] capBits, fsBits, expBits;
  logic [23:0] expL, expR;

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] frameOf(input logic [23:0] l, input logic [23:0] r,
                                          input logic w24, input logic [1:0] m);
    logic [63:0] f;
    for (int p = 0; p < 64; p++) begin
      int s = p / 32, j = p % 32, wl = w24 ? 24 : 16;
      logic [23:0] w = s ? r : l;
      f[p] = (!m[s] && j < wl) ? w[23-j] : 1'b0;
    end
    return f;
  endfunction

  function automatic logic [23:0] rxOf(input logic [23:0] w, input bit loop,
                                      input logic w24, input logic en);
    logic [23:0] v = loop ? w : 24'hFFFFFF;
    if (!en) return 24'h0;
    return w24 ? v : {v[23:8], 8'h00};
  endfunction

  task automatic step();
    @(negedge clk);
    cyc++; gap++;
    if (cyc > 190000) begin
      chk(0, "watchdog", 64'(cyc), 64'd0);
      finishRun();
    end
    if (bclk && !prevBclk) begin
      lastGap = gap; gap = 0;
      if (lastGap != 2 * expHalf) gapBad = 1;
      if (!fs && prevFs) pos = 0;
      else if (pos >= 0) pos = (pos + 1) % 64;
      prevFs = fs;
      if (pos >= 0) capBits[(pos + 63) % 64] = txd;
      if (pos == 0) begin
        if (fullFrame && compare) begin
          chk(capBits == expBits, "R3/R4/R5 tx frame", capBits, expBits);
          chk(fsBits == {32'hFFFFFFFF, 32'h0}, "R2 fs schedule", fsBits, {32'hFFFFFFFF, 32'h0});
          chk(!gapBad, "R1 bit period", 64'(lastGap), 64'(2 * expHalf));
          chk(rxPerFrame == 1, "R7 one pair per frame", 64'(rxPerFrame), 64'd1);
        end
        if (fullFrame) frames++;
        fullFrame = 1; gapBad = 0; rxPerFrame = 0;
      end
      if (pos >= 0) fsBits[pos] = fs;
    end
    prevBclk = bclk;
    if (rxValid) begin
      rxPerFrame++;
      if (compare) begin
        chk(rxLeft == expL, "R6 rx left", 64'(rxLeft), 64'(expL));
        chk(rxRight == expR, "R6 rx right", 64'(rxRight), 64'(expR));
      end
    end
  endtask

  task automatic runFrames(input int n, input bit cmp);
    int target = frames + n;
    compare = cmp;
    while (frames < target) step();
    compare = 0;
  endtask

  task automatic setup(input int div, input logic w24, input logic [1:0] m, input bit loop,
                       input logic [23:0] l, input logic [23:0] r, input bit offer);
    cfgDiv = 8'(div); cfgWord24 = w24; cfgMask = m; loopSel = loop;
    txLeft = l; txRight = r; txValid = offer;
    expHalf = (div == 0) ? 1 : div;
    expBits = offer ? frameOf(l, r, w24, m) : 64'h0;
    expL = rxOf(offer ? l : 24'h0, loop, w24, !m[0]);
    expR = rxOf(offer ? r : 24'h0, loop, w24, !m[1]);
  endtask

  initial begin
    rstN = 0; rxReady = 1; loopSel = 1;
    cfgDiv = 2; cfgWord24 = 1; cfgMask = 2'b00; txValid = 0; txLeft = 0; txRight = 0;
    repeat (5) step();
    // R9 reset state
    chk(bclk == 0, "R9 bclk", 64'(bclk), 0);
    chk(fs == 0, "R9 fs", 64'(fs), 0);
    chk(txd == 0, "R9 txd", 64'(txd), 0);
    chk(txReady == 1, "R9 txReady", 64'(txReady), 1);
    chk(rxValid == 0, "R9 rxValid", 64'(rxValid), 0);
    rstN = 1;

    // R8 idle: nothing offered, frames carry zeros
    setup(2, 1, 2'b00, 1, 24'h0, 24'h0, 0);
    runFrames(3, 0); runFrames(2, 1);

    // R8 single holding entry
    txLeft = 24'h123456; txRight = 24'h654321; txValid = 1;
    step(); txValid = 0;
    step();
    chk(txReady == 0, "R8 entry held", 64'(txReady), 0);
    runFrames(1, 0);
    chk(txReady == 1, "R8 entry drained", 64'(txReady), 1);

    // sweep word length x mask x receive source
    for (int w = 0; w < 2; w++)
      for (int m = 0; m < 4; m++)
        for (int lp = 0; lp < 2; lp++) begin
          int idx = w * 8 + m * 2 + lp;
          logic [23:0] l = 24'hA5C3E1 ^ (24'(idx) * 24'h13579B);
          logic [23:0] r = ~l ^ 24'(idx * 3);
          setup(2, w[0], 2'(m), lp[0], l, r, 1);
          runFrames(3, 0); runFrames(2, 1);
        end

    // R1 divider values, including 0 acting as 1
    setup(0, 1, 2'b00, 1, 24'h8001FF, 24'h7FFE00, 1);
    runFrames(3, 0); runFrames(2, 1);
    setup(3, 0, 2'b10, 1, 24'hC0FFEE, 24'h0BADF0, 1);
    runFrames(3, 0); runFrames(2, 1);
    setup(5, 1, 2'b01, 0, 24'hFEDCBA, 24'h012345, 1);
    runFrames(3, 0); runFrames(2, 1);

    // R10 mid-frame divider change waits for frame boundary
    setup(2, 1, 2'b00, 1, 24'h5A5A5A, 24'hA5A5A5, 1);
    runFrames(3, 0);
    while (pos != 10) step();
    cfgDiv = 4;
    while (pos != 40) step();
    chk(lastGap == 4, "R10 old divider kept in frame", 64'(lastGap), 64'd4);
    setup(4, 1, 2'b00, 1, 24'h5A5A5A, 24'hA5A5A5, 1);
    runFrames(3, 0); runFrames(2, 1);

    finishRun();
  end
endmodule